// File: doc/BRIEF.md
# External Memory Chip-Select Configuration Bank

This block holds one configuration byte for each of four external chip selects. Select 0 is the boot ROM, select 1 is flash, select 2 is synchronous SRAM and select 3 is expansion memory. Software programs the bytes through a simple synchronous register port. The port has a byte address, a write strobe, write data and combinational read data. The block decodes each byte into control fields for a separate access sequencer:

- a wait count in clock cycles,
- a synchronous/asynchronous flag,
- a write permission flag,
- an effective bus width.

A dedicated lock register write-protects the whole bank. The bank leaves reset locked, so configuration writes are dropped without any error response. Writing the 16-bit key 0xA05F to the lock register opens the bank. Writing any other value closes it again. Chip select 0 resets to a conservative setting that is safe for booting from ROM. The other selects reset to zero.

Top module: `extmem_cfg_regs`

## Requirements
- R1: After a synchronous reset the bank is locked, the select 0 byte is 0xF0 (wait code 15, asynchronous, writes disallowed, 8-bit), and the bytes for selects 1 to 3 are 0x00.
- R2: The configuration bytes sit at byte offsets 0x00, 0x04, 0x08 and 0x0C for selects 0 to 3. A read returns the stored byte in bits 7:0 with all upper bits zero, and an unlocked write stores bits 7:0 of the write data.
- R3: While the bank is locked, a write to any configuration offset leaves the stored byte and every decoded output unchanged.
- R4: A write to offset 0x20 whose bits 15:0 equal 0xA05F unlocks the bank. Bits 31:16 of that write are ignored.
- R5: A write to offset 0x20 with any other value in bits 15:0 locks the bank. A read of offset 0x20 returns 1 in bit 0 when the bank is locked and 0 when it is unlocked, with the other bits zero.
- R6: Byte bits 7:4 hold a wait code c. The decoded wait count is c+2 cycles for c from 0 to 13, and 16 cycles for codes 14 and 15.
- R7: Byte bit 3 drives the synchronous-mode output (1 = synchronous) and byte bit 2 drives the write-permission output (1 = writes allowed).
- R8: Byte bits 1:0 select the width: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit. Code 11 is stored and read back as written, but the decoded width output presents it as 10 (32-bit).
- R9: An access to an offset that is neither a configuration offset nor 0x20 is ignored on write and reads as zero. This includes offsets whose low two bits are nonzero.
- R10: Decoded outputs change only at the clock edge on which an accepted write is sampled, and they show the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| cs_wait_cycles | output | 20 | Wait count per select, 5 bits each, select 0 in the low bits |
| cs_sync | output | 4 | Synchronous-mode flag per select |
| cs_wr_ok | output | 4 | Write-permission flag per select |
| cs_width | output | 8 | Effective width code per select, 2 bits each |

## Verification
The assertions check several rules on every cycle:

- A locked bank never changes a decoded output on a non-lock write.
- The key value always opens the bank and any other lock value always closes it.
- Decoded wait counts stay within 2 to 16, and the decoded width never shows the reserved code.
- Unmapped or misaligned offsets always read zero.

Only the bench scenarios can show the exact byte-to-field mapping for specific values, the saturation of wait codes 14 and 15, and the readback of a stored reserved width. The same holds for ignoring the upper key bits, and for a mid-run reset restoring the boot-safe values.

// File: rtl/extmem_cfg_pkg.sv
package extmem_cfg_pkg;

    // Width encoding; the bit positions inside the byte are fixed by software.
    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_32  = 2'b10,
        WID_RSV = 2'b11
    } width_e;

    // Stored byte layout: [7:4] wait code, [3] sync, [2] write allow, [1:0] width.
    typedef struct packed {
        logic [3:0] wait_code;
        logic       sync_mode;
        logic       wr_allow;
        width_e     width;
    } cs_cfg_t;

    localparam int WAIT_W = 5;

    // Decoded control presented to the access sequencer.
    typedef struct packed {
        logic [WAIT_W-1:0] wait_cyc;
        logic              sync_mode;
        logic              wr_allow;
        width_e            width;
    } cs_ctrl_t;

    localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
    localparam logic [7:0]  BOOT_CS_RST = 8'hF0;
    localparam logic [7:0]  OTHER_CS_RST = 8'h00;

    // Wait code to cycle count: code+2, saturating at 16.
    function automatic logic [WAIT_W-1:0] wait_cycles(input logic [3:0] code);
        if (code >= 4'd14)
            return WAIT_W'(16);
        else
            return WAIT_W'(code) + WAIT_W'(2);
    endfunction

    // Reserved width is handled as 32-bit by the sequencer.
    function automatic width_e eff_width(input width_e w);
        return (w == WID_RSV) ? WID_32 : w;
    endfunction

    function automatic cs_ctrl_t decode_cfg(input cs_cfg_t c);
        cs_ctrl_t d;
        d.wait_cyc  = wait_cycles(c.wait_code);
        d.sync_mode = c.sync_mode;
        d.wr_allow  = c.wr_allow;
        d.width     = eff_width(c.width);
        return d;
    endfunction

endpackage

// File: rtl/extmem_cfg_decode.sv
module extmem_cfg_decode
    import extmem_cfg_pkg::*;
#(
    parameter int              ADDR_W    = 6,
    parameter int              NUM_CS    = 4,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 6'h20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] cfg_sel,
    output logic              lock_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    assign aligned  = (addr[1:0] == 2'b00);
    assign lock_sel = (addr == LOCK_ADDR);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign cfg_sel[i] = aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
    end

endmodule

// File: rtl/extmem_cfg_lock.sv
module extmem_cfg_lock
    import extmem_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [15:0] key_val,
    output logic        locked
);
    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b1;
        else if (key_wr)
            locked <= (key_val != UNLOCK_KEY);
    end
endmodule

// File: rtl/extmem_cfg_slot.sv
module extmem_cfg_slot
    import extmem_cfg_pkg::*;
#(
    parameter logic [7:0] RESET_VAL = 8'h00
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [7:0] wr_byte,
    output cs_cfg_t  cfg,
    output cs_ctrl_t ctrl
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= cs_cfg_t'(RESET_VAL);
        else if (wr_en)
            cfg <= cs_cfg_t'(wr_byte);
    end

    assign ctrl = decode_cfg(cfg);
endmodule

// File: rtl/extmem_cfg_regs.sv
module extmem_cfg_regs
    import extmem_cfg_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 32,
    parameter int                NUM_CS    = 4,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 6'h20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CS*WAIT_W-1:0] cs_wait_cycles,
    output logic [NUM_CS-1:0]        cs_sync,
    output logic [NUM_CS-1:0]        cs_wr_ok,
    output logic [NUM_CS*2-1:0]      cs_width
);
    logic [NUM_CS-1:0] cfg_sel;
    logic              lock_sel;
    logic              locked_q;
    cs_cfg_t           cfg_q  [NUM_CS];
    cs_ctrl_t          ctrl_d [NUM_CS];

    extmem_cfg_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CS    (NUM_CS),
        .LOCK_ADDR (LOCK_ADDR)
    ) u_decode (
        .addr     (bus_addr),
        .cfg_sel  (cfg_sel),
        .lock_sel (lock_sel)
    );

    extmem_cfg_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (bus_we && lock_sel),
        .key_val (bus_wdata[15:0]),
        .locked  (locked_q)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        extmem_cfg_slot #(
            .RESET_VAL ((i == 0) ? BOOT_CS_RST : OTHER_CS_RST)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_we && cfg_sel[i] && !locked_q),
            .wr_byte (bus_wdata[7:0]),
            .cfg     (cfg_q[i]),
            .ctrl    (ctrl_d[i])
        );

        assign cs_wait_cycles[i*WAIT_W +: WAIT_W] = ctrl_d[i].wait_cyc;
        assign cs_sync[i]                         = ctrl_d[i].sync_mode;
        assign cs_wr_ok[i]                        = ctrl_d[i].wr_allow;
        assign cs_width[i*2 +: 2]                 = ctrl_d[i].width;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_sel[i])
                bus_rdata[7:0] = cfg_q[i];
        end
        if (lock_sel)
            bus_rdata[0] = locked_q;
    end

endmodule

// File: rtl/extmem_cfg_chk.sv
module extmem_cfg_chk
    import extmem_cfg_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 32,
    parameter int                NUM_CS    = 4,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 6'h20
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_we,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [NUM_CS*WAIT_W-1:0] cs_wait_cycles,
    input logic [NUM_CS-1:0]        cs_sync,
    input logic [NUM_CS-1:0]        cs_wr_ok,
    input logic [NUM_CS*2-1:0]      cs_width,
    input logic                     locked_q
);
    localparam logic [ADDR_W-1:0] TOP_CFG = ADDR_W'((NUM_CS - 1) * 4);

    logic is_lock, unmapped;
    assign is_lock  = (bus_addr == LOCK_ADDR);
    assign unmapped = !is_lock && ((bus_addr[1:0] != 2'b00) || (bus_addr > TOP_CFG));

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> locked_q); // R1

    AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && locked_q && !is_lock) |=>
            ($stable(cs_wait_cycles) && $stable(cs_sync) && $stable(cs_wr_ok) && $stable(cs_width))); // R3

    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_lock && bus_wdata[15:0] == UNLOCK_KEY) |=> !locked_q); // R4

    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_lock && bus_wdata[15:0] != UNLOCK_KEY) |=> locked_q); // R5

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (bus_rdata == '0)); // R9

    for (genvar i = 0; i < NUM_CS; i++) begin : g_chk
        AST_WAIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            (cs_wait_cycles[i*WAIT_W +: WAIT_W] >= WAIT_W'(2)) &&
            (cs_wait_cycles[i*WAIT_W +: WAIT_W] <= WAIT_W'(16))); // R6

        AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
            cs_width[i*2 +: 2] != 2'b11); // R8
    end

endmodule

bind extmem_cfg_regs extmem_cfg_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_CS    (NUM_CS),
    .LOCK_ADDR (LOCK_ADDR)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .cs_wait_cycles (cs_wait_cycles),
    .cs_sync        (cs_sync),
    .cs_wr_ok       (cs_wr_ok),
    .cs_width       (cs_width),
    .locked_q       (locked_q)
);

// File: tb/test_extmem_cfg_regs.sv
module test_extmem_cfg_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 24;
    localparam logic K_RD = 1'b0;
    localparam logic K_WR = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [19:0] cs_wait_cycles;
    logic [3:0]  cs_sync, cs_wr_ok;
    logic [7:0]  cs_width;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extmem_cfg_regs i_extmem_cfg_regs (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .cs_wait_cycles (cs_wait_cycles),
        .cs_sync        (cs_sync),
        .cs_wr_ok       (cs_wr_ok),
        .cs_width       (cs_width)
    );

    // {req, kind, addr, data}: data is write data or expected read data.
    localparam logic [42:0] VEC [NV] = '{
        {4'd5, K_RD, 6'h20, 32'h0000_0001},
        {4'd1, K_RD, 6'h00, 32'h0000_00F0},
        {4'd1, K_RD, 6'h04, 32'h0000_0000},
        {4'd3, K_WR, 6'h04, 32'h0000_005D},
        {4'd3, K_RD, 6'h04, 32'h0000_0000},
        {4'd4, K_WR, 6'h20, 32'h0000_A05F},
        {4'd5, K_RD, 6'h20, 32'h0000_0000},
        {4'd2, K_WR, 6'h04, 32'h0000_005D},
        {4'd2, K_RD, 6'h04, 32'h0000_005D},
        {4'd2, K_WR, 6'h08, 32'hFFFF_FF3E},
        {4'd2, K_RD, 6'h08, 32'h0000_003E},
        {4'd8, K_WR, 6'h0C, 32'h0000_00E7},
        {4'd8, K_RD, 6'h0C, 32'h0000_00E7},
        {4'd9, K_WR, 6'h10, 32'h0000_0055},
        {4'd9, K_RD, 6'h10, 32'h0000_0000},
        {4'd9, K_WR, 6'h05, 32'h0000_0012},
        {4'd9, K_RD, 6'h04, 32'h0000_005D},
        {4'd9, K_RD, 6'h05, 32'h0000_0000},
        {4'd5, K_WR, 6'h20, 32'h1234_A05E},
        {4'd5, K_RD, 6'h20, 32'h0000_0001},
        {4'd3, K_WR, 6'h00, 32'h0000_0000},
        {4'd3, K_RD, 6'h00, 32'h0000_00F0},
        {4'd4, K_WR, 6'h20, 32'hFFFF_A05F},
        {4'd4, K_RD, 6'h20, 32'h0000_0000}
    };

    function automatic string req_tag(input int n);
        case (n)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic check_cs(input string tag, input int i, input logic [4:0] w,
                            input logic s, input logic e, input logic [1:0] wd);
        check(tag, {27'd0, cs_wait_cycles[i*5 +: 5]}, {27'd0, w});
        check(tag, {31'd0, cs_sync[i]}, {31'd0, s});
        check(tag, {31'd0, cs_wr_ok[i]}, {31'd0, e});
        check(tag, {30'd0, cs_width[i*2 +: 2]}, {30'd0, wd});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of decoded outputs
        check_cs("R1", 0, 5'd16, 1'b0, 1'b0, 2'b00);
        check_cs("R1", 3, 5'd2, 1'b0, 1'b0, 2'b00);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][38] == K_WR)
                bus_write(VEC[k][37:32], VEC[k][31:0]);
            else
                bus_read(req_tag(int'(VEC[k][42:39])), VEC[k][37:32], VEC[k][31:0]);
        end

        // R6 R7 R8: field decode of programmed bytes
        check_cs("R7", 1, 5'd7, 1'b1, 1'b1, 2'b01);
        check_cs("R6", 2, 5'd5, 1'b1, 1'b1, 2'b10);
        check_cs("R8", 3, 5'd16, 1'b0, 1'b1, 2'b10);
        check_cs("R6", 0, 5'd16, 1'b0, 1'b0, 2'b00);

        // R6: lowest and boundary wait codes
        bus_write(6'h04, 32'h0000_0000);
        check_cs("R6", 1, 5'd2, 1'b0, 1'b0, 2'b00);
        bus_write(6'h04, 32'h0000_00D4);
        check_cs("R6", 1, 5'd15, 1'b0, 1'b1, 2'b00);

        // R10: output holds before the edge, updates right after it
        @(negedge clk);
        bus_addr  = 6'h08;
        bus_wdata = 32'h0000_0061;
        bus_we    = 1'b1;
        #1;
        check_cs("R10", 2, 5'd5, 1'b1, 1'b1, 2'b10);
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        check_cs("R10", 2, 5'd8, 1'b0, 1'b0, 2'b01);

        // R3: locked write leaves outputs unchanged
        bus_write(6'h20, 32'h0000_0000);
        bus_write(6'h08, 32'h0000_00FF);
        check_cs("R3", 2, 5'd8, 1'b0, 1'b0, 2'b01);

        // R1: mid-run reset restores boot-safe values and lock
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_read("R1", 6'h20, 32'h1);
        bus_read("R1", 6'h00, 32'hF0);
        bus_read("R1", 6'h08, 32'h0);
        check_cs("R1", 2, 5'd2, 1'b0, 1'b0, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule